// File: doc/BRIEF.md
# Enable-Pulse Mode Switch Detector

This block decides whether a serial LED-driver style channel works in its normal mode or in its special mode. Both the active-low output enable (OE) and the latch strobe (LE) are sampled on rising clock edges. A single-clock low pulse on OE opens a short decision window. The LE level seen at one fixed edge inside that window sets the new mode. LE's usual latching role is blocked for the whole window.

The block never touches serial shifting or the output enable path. Those keep working through a transition, and the short OE pulse still turns the outputs on as usual. The block only reports the current mode. It also raises a blocking flag that the latch logic must respect, and it sends a one-cycle clear to the fault status store whenever normal mode is chosen. Because the switch sequence can start again at once, a controller may send it repeatedly to force a known mode.

Top module: `oe_mode_switch`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `mode_special_o` is 0 (normal mode), and `le_block_o` and `status_clr_o` are 0.
- R2: A trigger is OE sampled as 1, 0, 1 on three consecutive rising edges (edges 1, 2, 3), with the third edge seen while no window is open. `le_block_o` is 1 during the clock period that ends at edge 3.
- R3: The LE level sampled at edge 4 selects the mode (1 = special, 0 = normal). `mode_special_o` shows the new value from edge 4 onward.
- R4: `le_block_o` is 1 in the periods ending at edges 3, 4 and 5. It returns to 0 after edge 5 unless a new trigger begins.
- R5: The LE level at edges 3 and 5 has no effect on the chosen mode.
- R6: An OE low that lasts two or more sampled edges is not a trigger. Mode and blocking flag stay unchanged.
- R7: When the decision at edge 4 selects normal mode, `status_clr_o` is 1 for exactly the one period after edge 4. When it selects special mode, no clear is sent.
- R8: A 1, 0, 1 pattern whose third edge is edge 5 of an open window is ignored. A pattern whose third edge is edge 6 is accepted.
- R9: Outside a decision, LE activity does not change `mode_special_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all decisions use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe_n_i | input | 1 | Active-low output enable as seen on the pin |
| le_i | input | 1 | Latch strobe; selects the mode at the decision edge |
| mode_special_o | output | 1 | 1 = special mode, 0 = normal mode |
| le_block_o | output | 1 | 1 while LE must not latch data |
| status_clr_o | output | 1 | One-cycle clear to the fault status store when normal mode is chosen |

## Verification
Two things can happen in the same cycle: the tail of an open decision window, and the completion of a fresh OE trigger pattern. To provoke this, OE is driven so that its own 1, 0, 1 sequence ends at edge 5 or at edge 6 of the current window. The bench then checks that the first case leaves the blocking flag low after the window. In the second case the flag must stay high with no gap, and a second decision with its own clear pulse must follow.

// File: rtl/oe_mode_switch_pkg.sv
package oe_mode_switch_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_DECIDE = 2'd1,
    SEQ_TAIL   = 2'd2
  } seq_state_t;

endpackage

// File: rtl/oe_pulse_detect.sv
// Recognises a high / LOW_WIDTH-lows / high pattern on the sampled enable.
module oe_pulse_detect #(
  parameter int LOW_WIDTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n_i,
  output logic pulse_o
);
  localparam int HIST_W = LOW_WIDTH + 1;

  // hist[0] holds the most recent past sample; reset to 0 so that no
  // pre-reset high can stand in as the leading edge of a pattern.
  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= oe_n_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[HIST_W-2:0], oe_n_i};
      end
    end
  endgenerate

  // Current sample high, oldest high, every sample between them low.
  assign pulse_o = oe_n_i & hist_q[HIST_W-1] & ~(|hist_q[LOW_WIDTH-1:0]);

endmodule

// File: rtl/mode_sequencer.sv
// Runs the decision window: samples LE one edge after the trigger and
// keeps the window open for TAIL_CYCLES further edges.
module mode_sequencer
  import oe_mode_switch_pkg::*;
#(
  parameter int TAIL_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger_i,
  input  logic le_i,
  output logic window_o,
  output logic mode_o,
  output logic clr_o
);
  localparam int CNT_W = (TAIL_CYCLES > 1) ? $clog2(TAIL_CYCLES) : 1;

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      mode_o  <= 1'b0;
      clr_o   <= 1'b0;
    end else begin
      clr_o <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (trigger_i) state_q <= SEQ_DECIDE;
        end
        SEQ_DECIDE: begin
          mode_o  <= le_i;
          clr_o   <= ~le_i;
          cnt_q   <= CNT_W'(TAIL_CYCLES - 1);
          state_q <= (TAIL_CYCLES > 0) ? SEQ_TAIL : SEQ_IDLE;
        end
        SEQ_TAIL: begin
          if (cnt_q == '0) state_q <= SEQ_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign window_o = (state_q != SEQ_IDLE);

endmodule

// File: rtl/oe_mode_switch.sv
module oe_mode_switch #(
  parameter int LOW_WIDTH   = 1,
  parameter int TAIL_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n_i,
  input  logic le_i,
  output logic mode_special_o,
  output logic le_block_o,
  output logic status_clr_o
);
  logic pulse_raw;
  logic window;
  logic trigger;

  oe_pulse_detect #(.LOW_WIDTH(LOW_WIDTH)) u_detect (
    .clk     (clk),
    .rst     (rst),
    .oe_n_i  (oe_n_i),
    .pulse_o (pulse_raw)
  );

  // Patterns completing inside an open window are not accepted.
  assign trigger = pulse_raw & ~window;

  mode_sequencer #(.TAIL_CYCLES(TAIL_CYCLES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .trigger_i (trigger),
    .le_i      (le_i),
    .window_o  (window),
    .mode_o    (mode_special_o),
    .clr_o     (status_clr_o)
  );

  // The trigger edge itself must already suppress latching, so the
  // current-cycle pulse term is combined with the registered window.
  assign le_block_o = window | trigger;

endmodule

// File: rtl/oe_mode_switch_chk.sv
module oe_mode_switch_chk (
  input logic clk,
  input logic rst,
  input logic oe_n_i,
  input logic le_i,
  input logic mode_special_o,
  input logic le_block_o,
  input logic status_clr_o
);

  AST_MODE_FROM_LE: assert property (@(posedge clk) disable iff (rst)
    (mode_special_o != $past(mode_special_o)) |-> (mode_special_o == $past(le_i))); // R3

  AST_MODE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (mode_special_o != $past(mode_special_o)) |-> $past(le_block_o)); // R9

  AST_CLR_NORMAL: assert property (@(posedge clk) disable iff (rst)
    status_clr_o |-> !mode_special_o); // R7

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    status_clr_o |=> !status_clr_o); // R7

  AST_CLR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    status_clr_o |-> le_block_o); // R4

  AST_LONG_LOW: assert property (@(posedge clk) disable iff (rst)
    (oe_n_i && !$past(oe_n_i, 1) && !$past(oe_n_i, 2) && !$past(le_block_o))
      |-> !le_block_o); // R6

endmodule

bind oe_mode_switch oe_mode_switch_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .oe_n_i         (oe_n_i),
  .le_i           (le_i),
  .mode_special_o (mode_special_o),
  .le_block_o     (le_block_o),
  .status_clr_o   (status_clr_o)
);

// File: tb/tb_oe_mode_switch.sv
module tb_oe_mode_switch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_n = 1'b1;
  logic le = 1'b0;
  logic mode_special, le_block, status_clr;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic  m;
    logic  b;
    logic  c;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  oe_mode_switch dut (
    .clk            (clk),
    .rst            (rst),
    .oe_n_i         (oe_n),
    .le_i           (le),
    .mode_special_o (mode_special),
    .le_block_o     (le_block),
    .status_clr_o   (status_clr)
  );

  // Driver: inputs for one clock period, plus the outputs expected
  // at the middle of that period.
  task automatic cyc(input logic r, input logic o, input logic l,
                     input logic m, input logic b, input logic c,
                     input string req);
    @(posedge clk);
    #2;
    rst  = r;
    oe_n = o;
    le   = l;
    exp_q.push_back('{m, b, c, req});
  endtask

  // Monitor: compares in the half period after the inputs settle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compared++;
      if ({mode_special, le_block, status_clr} !== {e.m, e.b, e.c}) begin
        mismatched++;
        $display("FAIL %s: got mode=%b block=%b clr=%b expected mode=%b block=%b clr=%b",
                 e.req, mode_special, le_block, status_clr, e.m, e.b, e.c);
      end
    end
  end

  task automatic run_all;
    // R1 reset state and the first cycle after release
    cyc(1, 1, 0, 0, 0, 0, "R1");
    cyc(1, 1, 1, 0, 0, 0, "R1");
    cyc(0, 1, 1, 0, 0, 0, "R1");
    // R9 LE toggling while idle
    cyc(0, 1, 0, 0, 0, 0, "R9");
    cyc(0, 1, 1, 0, 0, 0, "R9");
    // Switch to special: edges 1..6
    cyc(0, 1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 1, 0, 0, 1, 0, "R2");
    cyc(0, 1, 1, 0, 1, 0, "R4");
    cyc(0, 1, 0, 1, 1, 0, "R3");
    cyc(0, 1, 0, 1, 0, 0, "R4");
    // R6 two-clock low is not a trigger
    cyc(0, 1, 1, 1, 0, 0, "R6");
    cyc(0, 0, 1, 1, 0, 0, "R6");
    cyc(0, 0, 0, 1, 0, 0, "R6");
    cyc(0, 1, 0, 1, 0, 0, "R6");
    cyc(0, 1, 1, 1, 0, 0, "R6");
    // Switch to normal, LE high at edges 3 and 5 (R5), clear pulse (R7)
    cyc(0, 1, 0, 1, 0, 0, "R2");
    cyc(0, 0, 0, 1, 0, 0, "R2");
    cyc(0, 1, 1, 1, 1, 0, "R5");
    cyc(0, 1, 0, 1, 1, 0, "R4");
    cyc(0, 1, 1, 0, 1, 1, "R7");
    cyc(0, 1, 1, 0, 0, 0, "R7");
    cyc(0, 1, 1, 0, 0, 0, "R9");
    // Special, then an immediate retrigger to normal at edge 6 (R8)
    cyc(0, 1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 1, 0, 0, 1, 0, "R2");
    cyc(0, 1, 1, 0, 1, 0, "R3");
    cyc(0, 0, 0, 1, 1, 0, "R3");
    cyc(0, 1, 1, 1, 1, 0, "R8");
    cyc(0, 1, 0, 1, 1, 0, "R8");
    cyc(0, 1, 0, 0, 1, 1, "R7");
    cyc(0, 1, 0, 0, 0, 0, "R8");
    // Pattern completing at edge 5 is ignored (R8), special chosen, no clear
    cyc(0, 1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 1, 0, 0, 1, 0, "R2");
    cyc(0, 0, 1, 0, 1, 0, "R3");
    cyc(0, 1, 0, 1, 1, 0, "R7");
    cyc(0, 1, 0, 1, 0, 0, "R8");
    cyc(0, 1, 1, 1, 0, 0, "R8");
    cyc(0, 1, 0, 1, 0, 0, "R9");
    // drain
    @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    fork
      begin
        run_all();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
      end
    join_any
    disable fork;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule